// File: doc/BRIEF.md
# Serial Write-Only Control Register Port

This block is a slave for a three-line serial link: an active-low select, a serial clock and a data line. While select is held low, the host shifts in a 16-bit frame, most significant bit first. The frame holds a 2-bit device code, which must be binary 11, then a direction bit, which must be 1 for a write. A 5-bit register index and an 8-bit value follow. The block samples each bit on a rising edge of the serial clock. It stores the value in one of 32 eight-bit registers only when select goes high again. All registers drive the output bus in parallel, and no path reads them back.

The three serial lines are asynchronous to the block. They pass through a synchroniser into a faster system clock and are edge-detected there. The system clock must run several times faster than the serial clock. The host therefore needs no timing relationship to the chip clock beyond that rate ratio.

Top module: `cfg_wport`

## Requirements
- R1: While `rst_n` is low, every register reads 0 on `regs_q`.
- R2: A frame of exactly 16 bits reading, MSB first, `11`, `1`, a 5-bit index A and an 8-bit value V, followed by release of `sel_n`, sets register A (bits `regs_q[8*A+7:8*A]`) to V. All other registers keep their values.
- R3: The value of a frame does not appear on `regs_q` before `sel_n` rises. It appears within a few system clocks after that rise.
- R4: A frame whose first two bits are not `11` changes no register.
- R5: A frame whose third bit is 0 changes no register.
- R6: A frame with fewer than 16 serial clock rising edges before `sel_n` rises changes no register.
- R7: A frame with more than 16 serial clock rising edges before `sel_n` rises changes no register.
- R8: Serial clock edges while `sel_n` is high are neither stored nor counted. The next framed write behaves as in R2.
- R9: Every index 0 to 31 addresses its own register, and each holds a written value until it is overwritten or reset.
- R10: Pulling `rst_n` low after writes returns all registers to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, several times faster than `ser_clk` |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_clk | input | 1 | Serial bit clock; data is sampled on its rising edge |
| sel_n | input | 1 | Active-low frame select; a rising edge commits the write |
| ser_din | input | 1 | Serial data, MSB first |
| regs_q | output | 256 | All 32 registers; register k occupies bits [8k+7:8k] |

## Verification
A wrong bit counter or shift order shows at the ports as a value in the wrong register, a bit-rotated value, or a rejected frame. A miscounted frame length shows as a short or long frame that still writes. Each of these is visible on `regs_q` a few system clocks after `sel_n` rises. A commit taken too early shows as a change while select is still low. Every check reads back the whole 256-bit bus, so writes that leak into neighbouring registers are caught.

// File: rtl/wp_pkg.sv
package wp_pkg;
   localparam int unsigned DEF_ID_W     = 2;
   localparam int unsigned DEF_ADDR_W   = 5;
   localparam int unsigned DEF_DATA_W   = 8;
   localparam int unsigned DEF_STAGES   = 2;

   function automatic int unsigned frame_bits(input int unsigned id_w,
                                              input int unsigned addr_w,
                                              input int unsigned data_w);
      return id_w + 1 + addr_w + data_w;
   endfunction
endpackage

// File: rtl/wp_sync.sv
module wp_sync #(
   parameter int unsigned WIDTH   = 1,
   parameter int unsigned STAGES  = 2,
   parameter logic [WIDTH-1:0] RST_VAL = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);
   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("wp_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [WIDTH-1:0] chain [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < int'(STAGES); i++) chain[i] <= RST_VAL;
      end else begin
         chain[0] <= d;
         for (int i = 1; i < int'(STAGES); i++) chain[i] <= chain[i-1];
      end
   end

   assign q = chain[STAGES-1];
endmodule

// File: rtl/wp_frame.sv
module wp_frame #(
   parameter int unsigned ID_W   = 2,
   parameter int unsigned ADDR_W = 5,
   parameter int unsigned DATA_W = 8,
   parameter logic [ID_W-1:0] DEV_ID = '1,
   localparam int unsigned FRAME_W = ID_W + 1 + ADDR_W + DATA_W,
   localparam int unsigned CNT_W   = $clog2(FRAME_W + 2)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               idle,
   input  logic               bit_stb,
   input  logic               commit,
   input  logic               din,
   output logic               wr_en,
   output logic [ADDR_W-1:0]  wr_addr,
   output logic [DATA_W-1:0]  wr_data,
   output logic [CNT_W-1:0]   bit_cnt,
   output logic [FRAME_W-1:0] frame
);
   localparam logic [CNT_W-1:0] FULL = CNT_W'(FRAME_W);
   localparam logic [CNT_W-1:0] OVER = CNT_W'(FRAME_W + 1);
   localparam int unsigned DIR_POS   = ADDR_W + DATA_W;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bit_cnt <= '0;
         frame   <= '0;
      end else if (idle) begin
         bit_cnt <= '0;
      end else if (bit_stb) begin
         frame <= {frame[FRAME_W-2:0], din};
         if (bit_cnt != OVER) bit_cnt <= bit_cnt + 1'b1;
      end
   end

   logic id_ok, dir_ok, len_ok;
   assign id_ok   = frame[FRAME_W-1 -: ID_W] == DEV_ID;
   assign dir_ok  = frame[DIR_POS];
   assign len_ok  = bit_cnt == FULL;
   assign wr_en   = commit && id_ok && dir_ok && len_ok;
   assign wr_addr = frame[DATA_W +: ADDR_W];
   assign wr_data = frame[DATA_W-1:0];
endmodule

// File: rtl/wp_regbank.sv
module wp_regbank #(
   parameter int unsigned ADDR_W = 5,
   parameter int unsigned DATA_W = 8,
   localparam int unsigned NREG  = 1 << ADDR_W
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     wr_en,
   input  logic [ADDR_W-1:0]        wr_addr,
   input  logic [DATA_W-1:0]        wr_data,
   output logic [NREG*DATA_W-1:0]   q
);
   generate
      for (genvar g = 0; g < int'(NREG); g++) begin : g_reg
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               q[g*DATA_W +: DATA_W] <= '0;
            else if (wr_en && wr_addr == ADDR_W'(g))
               q[g*DATA_W +: DATA_W] <= wr_data;
         end
      end
   endgenerate
endmodule

// File: rtl/cfg_wport.sv
module cfg_wport #(
   parameter int unsigned ID_W   = wp_pkg::DEF_ID_W,
   parameter int unsigned ADDR_W = wp_pkg::DEF_ADDR_W,
   parameter int unsigned DATA_W = wp_pkg::DEF_DATA_W,
   parameter int unsigned STAGES = wp_pkg::DEF_STAGES,
   parameter logic [ID_W-1:0] DEV_ID = '1,
   localparam int unsigned NREG    = 1 << ADDR_W,
   localparam int unsigned FRAME_W = wp_pkg::frame_bits(ID_W, ADDR_W, DATA_W),
   localparam int unsigned CNT_W   = $clog2(FRAME_W + 2)
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   ser_clk,
   input  logic                   sel_n,
   input  logic                   ser_din,
   output logic [NREG*DATA_W-1:0] regs_q
);
   generate
      if (ID_W < 1 || ADDR_W < 1 || DATA_W < 1) begin : g_bad_width
         $error("cfg_wport: field widths must be non-zero");
      end
      if (ADDR_W > 8) begin : g_bad_depth
         $error("cfg_wport: ADDR_W above 8 makes the bank too large");
      end
   endgenerate

   // bit 0: serial clock, bit 1: select (idle high), bit 2: data
   logic [2:0] raw, syn;
   assign raw = {ser_din, sel_n, ser_clk};

   wp_sync #(.WIDTH(3), .STAGES(STAGES), .RST_VAL(3'b010)) u_sync (
      .clk(clk), .rst_n(rst_n), .d(raw), .q(syn));

   logic sclk_prev, sel_prev;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sclk_prev <= 1'b0;
         sel_prev  <= 1'b1;
      end else begin
         sclk_prev <= syn[0];
         sel_prev  <= syn[1];
      end
   end

   logic sclk_rise, sel_rise, sel_lvl;
   assign sel_lvl   = syn[1];
   assign sclk_rise = syn[0] & ~sclk_prev;
   assign sel_rise  = syn[1] & ~sel_prev;

   logic               wr_en;
   logic [ADDR_W-1:0]  wr_addr;
   logic [DATA_W-1:0]  wr_data;
   logic [CNT_W-1:0]   bit_cnt;
   logic [FRAME_W-1:0] frame;

   wp_frame #(.ID_W(ID_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .DEV_ID(DEV_ID)) u_frame (
      .clk(clk), .rst_n(rst_n), .idle(sel_lvl), .bit_stb(sclk_rise),
      .commit(sel_rise), .din(syn[2]), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .bit_cnt(bit_cnt), .frame(frame));

   wp_regbank #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_bank (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .q(regs_q));
endmodule

// File: rtl/wp_checker.sv
module wp_checker #(
   parameter int unsigned ID_W    = 2,
   parameter int unsigned FRAME_W = 16,
   parameter int unsigned CNT_W   = 5,
   parameter int unsigned QW      = 256,
   parameter logic [ID_W-1:0] DEV_ID = '1
) (
   input logic               clk,
   input logic               rst_n,
   input logic               sel_rise,
   input logic               sel_lvl,
   input logic [CNT_W-1:0]   bit_cnt,
   input logic [FRAME_W-1:0] frame,
   input logic [QW-1:0]      regs_q
);
   a_r1_reset_clears: assert property (@(posedge clk)
      !rst_n |-> regs_q == '0);

   a_r3_no_change_without_release: assert property (@(posedge clk) disable iff (!rst_n)
      !sel_rise |=> $stable(regs_q));

   a_r4_foreign_id_ignored: assert property (@(posedge clk) disable iff (!rst_n)
      (sel_rise && frame[FRAME_W-1 -: ID_W] != DEV_ID) |=> $stable(regs_q));

   a_r5_read_dir_ignored: assert property (@(posedge clk) disable iff (!rst_n)
      (sel_rise && !frame[FRAME_W-ID_W-1]) |=> $stable(regs_q));

   a_r6_short_ignored: assert property (@(posedge clk) disable iff (!rst_n)
      (sel_rise && bit_cnt < CNT_W'(FRAME_W)) |=> $stable(regs_q));

   a_r7_long_ignored: assert property (@(posedge clk) disable iff (!rst_n)
      (sel_rise && bit_cnt > CNT_W'(FRAME_W)) |=> $stable(regs_q));

   a_r7_count_bounded: assert property (@(posedge clk) disable iff (!rst_n)
      bit_cnt <= CNT_W'(FRAME_W + 1));

   a_r8_idle_clears_count: assert property (@(posedge clk) disable iff (!rst_n)
      sel_lvl |=> bit_cnt == '0);
endmodule

bind cfg_wport wp_checker #(
   .ID_W(ID_W), .FRAME_W(FRAME_W), .CNT_W(CNT_W), .QW(NREG*DATA_W), .DEV_ID(DEV_ID)
) u_chk (
   .clk(clk), .rst_n(rst_n), .sel_rise(sel_rise), .sel_lvl(sel_lvl),
   .bit_cnt(bit_cnt), .frame(frame), .regs_q(regs_q));

// File: tb/sim_cfg_wport.sv
`timescale 1ns/1ps
module sim_cfg_wport;
   logic clk = 1'b0;
   logic rst_n = 1'b1;
   logic ser_clk = 1'b0;
   logic sel_n = 1'b1;
   logic ser_din = 1'b0;
   logic [255:0] regs_q;

   int checks = 0;
   int fails  = 0;
   logic [7:0] model [32];
   bit done = 0;

   always #5 clk = ~clk;

   cfg_wport u0 (.clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .sel_n(sel_n),
                 .ser_din(ser_din), .regs_q(regs_q));

   function automatic logic [15:0] mk(input logic [1:0] id, input logic dir,
                                      input logic [4:0] a, input logic [7:0] v);
      return {id, dir, a, v};
   endfunction

   task automatic shift_in(input logic [31:0] bits, input int n);
      sel_n = 1'b0;
      #80;
      for (int i = n - 1; i >= 0; i--) begin
         ser_din = bits[i];
         #40 ser_clk = 1'b1;
         #40 ser_clk = 1'b0;
      end
      #40;
   endtask

   task automatic release_sel();
      sel_n = 1'b1;
      #200;
   endtask

   task automatic frame_wr(input logic [31:0] bits, input int n);
      shift_in(bits, n);
      release_sel();
   endtask

   task automatic check_all(input string req);
      for (int k = 0; k < 32; k++) begin
         checks++;
         if (regs_q[k*8 +: 8] !== model[k]) begin
            fails++;
            $display("FAIL %s reg %0d actual=%h expected=%h", req, k, regs_q[k*8 +: 8], model[k]);
         end
      end
   endtask

   initial begin
      #(2_000_000);
      if (!done) begin
         fails++; checks++;
         $display("FAIL watchdog expired");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin
      for (int k = 0; k < 32; k++) model[k] = 8'h00;
      #1 rst_n = 1'b0;
      #50;
      check_all("R1");
      rst_n = 1'b1;
      #50;

      // R2: a single write, only the target changes
      frame_wr({16'h0, mk(2'b11, 1'b1, 5'd5, 8'hC3)}, 16);
      model[5] = 8'hC3;
      check_all("R2");

      // R3: no commit while select is still low
      shift_in({16'h0, mk(2'b11, 1'b1, 5'd9, 8'h5A)}, 16);
      #300;
      check_all("R3 before release");
      release_sel();
      model[9] = 8'h5A;
      check_all("R3 after release");

      // R4: foreign device codes
      frame_wr({16'h0, mk(2'b01, 1'b1, 5'd9, 8'hFF)}, 16);
      frame_wr({16'h0, mk(2'b10, 1'b1, 5'd9, 8'hFF)}, 16);
      frame_wr({16'h0, mk(2'b00, 1'b1, 5'd9, 8'hFF)}, 16);
      check_all("R4");

      // R5: direction bit 0
      frame_wr({16'h0, mk(2'b11, 1'b0, 5'd5, 8'h11)}, 16);
      check_all("R5");

      // R6: short frames (15 bits and 0 bits)
      frame_wr({17'h0, mk(2'b11, 1'b1, 5'd5, 8'h77) >> 1}, 15);
      frame_wr(32'h0, 0);
      check_all("R6");

      // R7: long frames; final 16 bits would form a valid write
      frame_wr({15'h0, 1'b1, mk(2'b11, 1'b1, 5'd6, 8'h99)}, 17);
      frame_wr({8'hFF, 8'hFF, mk(2'b11, 1'b1, 5'd6, 8'h99)}, 32);
      check_all("R7");

      // R8: serial clocks with select high are ignored
      for (int i = 0; i < 7; i++) begin
         ser_din = i[0];
         #40 ser_clk = 1'b1;
         #40 ser_clk = 1'b0;
      end
      #200;
      check_all("R8 idle clocks");
      frame_wr({16'h0, mk(2'b11, 1'b1, 5'd31, 8'h81)}, 16);
      model[31] = 8'h81;
      check_all("R8 write after idle clocks");

      // R9: sweep every index with computed values, then overwrite
      for (int a = 0; a < 32; a++) begin
         logic [7:0] v;
         v = 8'((a * 37 + 11) ^ (a << 3));
         frame_wr({16'h0, mk(2'b11, 1'b1, 5'(a), v)}, 16);
         model[a] = v;
      end
      check_all("R9 sweep");
      for (int a = 0; a < 32; a += 3) begin
         logic [7:0] v;
         v = (a % 2 == 0) ? 8'hFF : 8'h00;
         frame_wr({16'h0, mk(2'b11, 1'b1, 5'(a), v)}, 16);
         model[a] = v;
      end
      check_all("R9 overwrite");

      // R10: reset after writes
      rst_n = 1'b0;
      #30;
      for (int k = 0; k < 32; k++) model[k] = 8'h00;
      check_all("R10");
      rst_n = 1'b1;
      #50;
      frame_wr({16'h0, mk(2'b11, 1'b1, 5'd0, 8'h01)}, 16);
      model[0] = 8'h01;
      check_all("R10 write after reset");

      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule